// File: doc/BRIEF.md
# Key-Unlocked Configuration Register Bank

This block is a small word-addressed register file that presents a configuration header of the kind found on add-in bus devices. A host writes and reads it through a plain port: a write enable, a word index, 32-bit write data, four byte strobes and combinational read data. The bank does not handle bus protocol or transaction decode. It only holds the header fields and decides, field by field, whether a write may change them.

Three separate gates control writability. The first is a configuration-management mode bit in a setup word. The second is a write-once latch on the class code. The third is a pair of magic-key locks: each lock opens when the key byte 0xCA is written to it, and each closes again by itself once the register group it protects is written. The block also drives the decoded base address, together with a flag that stays low for a fixed settling window after every accepted base-address write.

Top module: `cfg_hdr_bank`

## Requirements
- R1: After reset the reads are: word 0 = 0x5406_1131, word 1 = 0x0290_0000, words 2 through 8 = 0. The output base_addr is 0 and base_addr_stable is 1. Both key locks are closed and the mode bit (setup word bit 1) is 0.
- R2: Word 0 (device ID in bits 31:16, vendor ID in bits 15:0) is read-only. Writes to it leave it unchanged.
- R3: In word 1, the command field (bits 15:0) accepts writes only while the mode bit is 1. The status field (bits 31:16) always reads 0x0290.
- R4: In word 3, the latency field (bits 15:8) and the line-size field (bits 7:0) accept writes only while the mode bit is 1. Bits 31:16 always read 0.
- R5: Word 4, the base address, accepts writes only while the mode bit is 1. Only bits 31:21 are kept, bits 20:0 read 0, and base_addr shows the same value as word 4.
- R6: An accepted base-address write drives base_addr_stable to 0 after that clock edge. The flag returns to 1 after exactly 10 further edges. A new accepted write restarts the count. A rejected write leaves the flag unchanged.
- R7: Word 8 is the key word and always reads 0. Byte 1 holding 0xCA with wstrb[1] set opens lock A. Byte 0 holding 0xCA with wstrb[0] set opens lock B. Any other value, or a cleared strobe, leaves the lock as it was.
- R8: Word 5 (subsystem ID in bits 31:16, subsystem vendor in bits 15:0) is writable only while lock A is open. Any write to word 5 closes lock A.
- R9: Lock B guards word 6 (maximum latency in bits 15:8, minimum grant in bits 7:0), word 7 (setup, bits 7:0) and the class code. Any write to word 7 closes lock B. Writes to word 6 leave lock B open.
- R10: The class code (word 2, bits 31:8) takes only the first write made while lock B is open. Later writes leave it unchanged. The revision byte (bits 7:0) reads 0.
- R11: In any write-enabled field, only the bytes whose wstrb bit is set are updated.
- R12: Word indices 9 through 15 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request for the current cycle |
| addr | input | ADDR_W | Word index |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte strobes, bit n selects bits 8n+7:8n |
| rdata | output | 32 | Read data for addr (combinational) |
| base_addr | output | 32 | Current base address |
| base_addr_stable | output | 1 | High when base_addr has settled |

## Verification
The bench checks the relock paths. If a group failed to close after its protected word was written, the second write to word 5 or word 7 would land instead of being dropped. Near-miss keys are tried: the right value with the wrong strobe, and the wrong value with the right strobe. A design that tested only one of the two would open a lock. The class code gets a second write while lock B is still open, which exposes a design that keys the class code on the lock alone. The settle flag is sampled on every edge of the window and again after a restart. An off-by-one counter would therefore flip one edge early or late, and a design that ignores the restart would rise too soon.

// File: rtl/cfg_hdr_pkg.sv
// Shared constants for the configuration register bank: word indices,
// the unlock key and the reset images of the fixed fields.
package cfg_hdr_pkg;
    localparam int          W_ID      = 0;
    localparam int          W_CMD     = 1;
    localparam int          W_CLASS   = 2;
    localparam int          W_MISC    = 3;
    localparam int          W_BAR     = 4;
    localparam int          W_SSYS    = 5;
    localparam int          W_LIMIT   = 6;
    localparam int          W_SETUP   = 7;
    localparam int          W_KEY     = 8;
    localparam logic [7:0]  UNLOCK_KEY = 8'hCA;
    localparam logic [31:0] ID_WORD    = 32'h5406_1131;
    localparam logic [15:0] STATUS_VAL = 16'h0290;
    localparam int          MODE_BIT   = 1;
endpackage

// File: rtl/cfg_field_reg.sv
// Byte-strobed storage for one writable field of NBYTES bytes.
// Assumes the caller has already gated 'we' with every write permission.
module cfg_field_reg #(
    parameter int                 NBYTES = 2,
    parameter logic [NBYTES*8-1:0] RESET = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [NBYTES-1:0]   be,
    input  logic [NBYTES*8-1:0] d,
    output logic [NBYTES*8-1:0] q
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Update one byte lane when the write is allowed and its strobe is set.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[b*8 +: 8] <= RESET[b*8 +: 8];
            else if (we && be[b])
                q[b*8 +: 8] <= d[b*8 +: 8];
        end
    end
endmodule

// File: rtl/cfg_key_lock.sv
// One self-closing lock: opens on a matching key byte, closes when the
// guarded group is written. A close and an open never coincide in the
// same cycle, because they come from different word indices.
module cfg_key_lock #(
    parameter logic [7:0] KEY = 8'hCA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [7:0] key_byte,
    input  logic       relock,
    output logic       open
);
    // Track the lock state; a close request wins over a key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open <= 1'b0;
        else if (relock)
            open <= 1'b0;
        else if (key_we && key_byte == KEY)
            open <= 1'b1;
    end
endmodule

// File: rtl/cfg_settle_timer.sv
// Down-counter that holds 'settled' low for CYCLES edges after each start.
// Assumes CYCLES >= 1.
module cfg_settle_timer #(
    parameter int CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic settled
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt;

    // Reload on start, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign settled = (cnt == '0);
endmodule

// File: rtl/cfg_hdr_bank.sv
// Configuration header register bank. Decodes host writes to word
// indices, applies the mode-bit, key-lock and write-once gates per field,
// and returns read data combinationally. Assumes one access per cycle.
module cfg_hdr_bank
    import cfg_hdr_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int SETTLE_CYCLES = 10,
    parameter int BAR_LSB       = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    output logic [31:0]       rdata,
    output logic [31:0]       base_addr,
    output logic              base_addr_stable
);
    localparam logic [31:0] BAR_MASK = ~((32'd1 << BAR_LSB) - 32'd1);

    logic        hit_cmd, hit_class, hit_misc, hit_bar;
    logic        hit_ssys, hit_limit, hit_setup, hit_key;
    logic        open_a, open_b, mode_en, class_done;
    logic        we_cmd, we_class, we_misc, we_bar, we_ssys, we_limit, we_setup;
    logic [15:0] cmd_q, misc_q, limit_q;
    logic [23:0] class_q;
    logic [31:0] bar_q, ssys_q;
    logic [7:0]  setup_q;

    // Decode which word the current write addresses.
    always_comb begin
        hit_cmd   = wr_en && (addr == ADDR_W'(W_CMD));
        hit_class = wr_en && (addr == ADDR_W'(W_CLASS));
        hit_misc  = wr_en && (addr == ADDR_W'(W_MISC));
        hit_bar   = wr_en && (addr == ADDR_W'(W_BAR));
        hit_ssys  = wr_en && (addr == ADDR_W'(W_SSYS));
        hit_limit = wr_en && (addr == ADDR_W'(W_LIMIT));
        hit_setup = wr_en && (addr == ADDR_W'(W_SETUP));
        hit_key   = wr_en && (addr == ADDR_W'(W_KEY));
    end

    assign mode_en = setup_q[MODE_BIT];

    // Combine each field's permission gate with its decode.
    always_comb begin
        we_cmd   = hit_cmd   && mode_en;
        we_misc  = hit_misc  && mode_en;
        we_bar   = hit_bar   && mode_en;
        we_ssys  = hit_ssys  && open_a;
        we_limit = hit_limit && open_b;
        we_setup = hit_setup && open_b;
        we_class = hit_class && open_b && !class_done;
    end

    cfg_key_lock #(.KEY(UNLOCK_KEY)) u_lock_a (
        .clk(clk), .rst_n(rst_n), .key_we(hit_key && wstrb[1]),
        .key_byte(wdata[15:8]), .relock(hit_ssys), .open(open_a)
    );

    cfg_key_lock #(.KEY(UNLOCK_KEY)) u_lock_b (
        .clk(clk), .rst_n(rst_n), .key_we(hit_key && wstrb[0]),
        .key_byte(wdata[7:0]), .relock(hit_setup), .open(open_b)
    );

    // Latch that the class code has taken its single write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            class_done <= 1'b0;
        else if (we_class)
            class_done <= 1'b1;
    end

    cfg_field_reg #(.NBYTES(2)) u_cmd (
        .clk(clk), .rst_n(rst_n), .we(we_cmd), .be(wstrb[1:0]),
        .d(wdata[15:0]), .q(cmd_q)
    );
    cfg_field_reg #(.NBYTES(3)) u_class (
        .clk(clk), .rst_n(rst_n), .we(we_class), .be(wstrb[3:1]),
        .d(wdata[31:8]), .q(class_q)
    );
    cfg_field_reg #(.NBYTES(2)) u_misc (
        .clk(clk), .rst_n(rst_n), .we(we_misc), .be(wstrb[1:0]),
        .d(wdata[15:0]), .q(misc_q)
    );
    cfg_field_reg #(.NBYTES(4)) u_bar (
        .clk(clk), .rst_n(rst_n), .we(we_bar), .be(wstrb),
        .d(wdata), .q(bar_q)
    );
    cfg_field_reg #(.NBYTES(4)) u_ssys (
        .clk(clk), .rst_n(rst_n), .we(we_ssys), .be(wstrb),
        .d(wdata), .q(ssys_q)
    );
    cfg_field_reg #(.NBYTES(2)) u_limit (
        .clk(clk), .rst_n(rst_n), .we(we_limit), .be(wstrb[1:0]),
        .d(wdata[15:0]), .q(limit_q)
    );
    cfg_field_reg #(.NBYTES(1)) u_setup (
        .clk(clk), .rst_n(rst_n), .we(we_setup), .be(wstrb[0]),
        .d(wdata[7:0]), .q(setup_q)
    );

    cfg_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .start(we_bar), .settled(base_addr_stable)
    );

    assign base_addr = bar_q & BAR_MASK;

    // Select read data for the addressed word; key and unmapped words read 0.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(W_ID):    rdata = ID_WORD;
            ADDR_W'(W_CMD):   rdata = {STATUS_VAL, cmd_q};
            ADDR_W'(W_CLASS): rdata = {class_q, 8'h00};
            ADDR_W'(W_MISC):  rdata = {16'h0000, misc_q};
            ADDR_W'(W_BAR):   rdata = base_addr;
            ADDR_W'(W_SSYS):  rdata = ssys_q;
            ADDR_W'(W_LIMIT): rdata = {16'h0000, limit_q};
            ADDR_W'(W_SETUP): rdata = {24'h000000, setup_q};
            default:          rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_hdr_bank_chk.sv
// Temporal checks on the register bank, attached through bind.
module cfg_hdr_bank_chk
    import cfg_hdr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic [31:0]       base_addr,
    input logic              base_addr_stable,
    input logic              open_a,
    input logic              open_b,
    input logic              class_done,
    input logic [23:0]       class_q
);
    a_r2_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(W_ID)) |-> (rdata == ID_WORD));

    a_r3_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(W_CMD)) |-> (rdata[31:16] == STATUS_VAL));

    a_r6_unsettled_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(base_addr) |-> !base_addr_stable);

    a_r7_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(W_KEY)) |-> (rdata == 32'h0));

    a_r8_ssys_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(W_SSYS)) |=> !open_a);

    a_r9_setup_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(W_SETUP)) |=> !open_b);

    a_r10_class_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        class_done |=> $stable(class_q));

    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > ADDR_W'(W_KEY)) |-> (rdata == 32'h0));
endmodule

bind cfg_hdr_bank cfg_hdr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
    .base_addr(base_addr), .base_addr_stable(base_addr_stable),
    .open_a(open_a), .open_b(open_b), .class_done(class_done),
    .class_q(class_q)
);

// File: tb/test_cfg_hdr_bank.sv
module test_cfg_hdr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic [31:0] rdata, base_addr;
    logic        base_addr_stable;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    cfg_hdr_bank i_cfg_hdr_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .wstrb(wstrb), .rdata(rdata), .base_addr(base_addr),
        .base_addr_stable(base_addr_stable)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  a;
        logic [31:0] d;
        logic [3:0]  s;
        logic [31:0] exp;
    } vec_t;

    // Each step: optional write, then read the same word.
    localparam vec_t VECS [24] = '{
        '{1'b1, 4'd0, 32'hFFFF_FFFF, 4'hF, 32'h5406_1131}, // R2
        '{1'b1, 4'd1, 32'hFFFF_FFFF, 4'hF, 32'h0290_0000}, // R3 mode off
        '{1'b1, 4'd7, 32'h0000_0002, 4'hF, 32'h0000_0000}, // R9 locked
        '{1'b1, 4'd8, 32'h0000_00CA, 4'h1, 32'h0000_0000}, // R7 open B
        '{1'b1, 4'd6, 32'h0000_1234, 4'h3, 32'h0000_1234}, // R9 limits
        '{1'b1, 4'd7, 32'h0000_0002, 4'h1, 32'h0000_0002}, // R9 setup
        '{1'b1, 4'd7, 32'h0000_0000, 4'h1, 32'h0000_0002}, // R9 relocked
        '{1'b1, 4'd1, 32'hFFFF_0107, 4'h1, 32'h0290_0007}, // R3 R11
        '{1'b1, 4'd1, 32'h0000_AB00, 4'h2, 32'h0290_AB07}, // R11
        '{1'b1, 4'd3, 32'hFFFF_4020, 4'hF, 32'h0000_4020}, // R4
        '{1'b1, 4'd5, 32'h1111_2222, 4'hF, 32'h0000_0000}, // R8 locked
        '{1'b1, 4'd8, 32'h0000_5500, 4'h2, 32'h0000_0000}, // R7 bad key
        '{1'b1, 4'd5, 32'h1111_2222, 4'hF, 32'h0000_0000}, // R7 still shut
        '{1'b1, 4'd8, 32'h0000_CA00, 4'h1, 32'h0000_0000}, // R7 wrong strobe
        '{1'b1, 4'd5, 32'h1111_2222, 4'hF, 32'h0000_0000}, // R7 still shut
        '{1'b1, 4'd8, 32'h0000_CA00, 4'h2, 32'h0000_0000}, // R7 open A
        '{1'b1, 4'd5, 32'h1111_2222, 4'hF, 32'h1111_2222}, // R8
        '{1'b1, 4'd5, 32'h3333_4444, 4'hF, 32'h1111_2222}, // R8 relocked
        '{1'b1, 4'd2, 32'hABCD_EF99, 4'hF, 32'h0000_0000}, // R10 B shut
        '{1'b1, 4'd8, 32'h0000_00CA, 4'h1, 32'h0000_0000}, // R7 open B
        '{1'b1, 4'd2, 32'hABCD_EF99, 4'hF, 32'hABCD_EF00}, // R10 first
        '{1'b1, 4'd2, 32'h1234_5600, 4'hF, 32'hABCD_EF00}, // R10 once
        '{1'b1, 4'd6, 32'h0000_5678, 4'h2, 32'h0000_5634}, // R11
        '{1'b1, 4'd15, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000} // R12
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; wstrb = s;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic reset_check();
        rd_check("R1 id", 4'd0, 32'h5406_1131);
        rd_check("R1 cmd", 4'd1, 32'h0290_0000);
        for (int w = 2; w <= 8; w++) rd_check("R1 zero", 4'(w), 32'h0);
        check("R1 base", base_addr, 32'h0);
        check("R1 stable", {31'h0, base_addr_stable}, 32'h1);
    endtask

    task automatic settle_window(input string req);
        check(req, {31'h0, base_addr_stable}, 32'h0);
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk); #1;
            check(req, {31'h0, base_addr_stable}, 32'h0);
        end
        @(negedge clk); #1;
        check(req, {31'h0, base_addr_stable}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        reset_check();  // R1

        foreach (VECS[i]) begin
            @(negedge clk);
            wr_en = VECS[i].we; addr = VECS[i].a;
            wdata = VECS[i].d;  wstrb = VECS[i].s;
            @(negedge clk);
            wr_en = 1'b0;
            #1;
            check($sformatf("vector %0d", i), rdata, VECS[i].exp);
        end
        rd_check("R12 read", 4'd9, 32'h0);

        // R5 R6: base address with mode on, full settle window
        wr(4'd4, 32'hFFFF_FFFF, 4'hF);
        check("R5 base", base_addr, 32'hFFE0_0000);
        settle_window("R6 window");
        rd_check("R5 read", 4'd4, 32'hFFE0_0000);

        // R6: restart in the middle of the window
        wr(4'd4, 32'h1234_5678, 4'hF);
        check("R5 mask", base_addr, 32'h1220_0000);
        repeat (5) @(negedge clk);
        #1;
        check("R6 mid", {31'h0, base_addr_stable}, 32'h0);
        wr(4'd4, 32'h8000_0000, 4'hF);
        settle_window("R6 restart");

        // Mode off: R3 R4 R5 R6 writes rejected
        wr(4'd7, 32'h0, 4'h1);
        rd_check("R9 setup cleared", 4'd7, 32'h0);
        wr(4'd4, 32'h0, 4'hF);
        check("R5 rejected", base_addr, 32'h8000_0000);
        check("R6 no drop", {31'h0, base_addr_stable}, 32'h1);
        wr(4'd1, 32'h0, 4'hF);
        rd_check("R3 rejected", 4'd1, 32'h0290_AB07);
        wr(4'd3, 32'h0, 4'hF);
        rd_check("R4 rejected", 4'd3, 32'h0000_4020);

        // R1: reset mid-run restores defaults and closes locks
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        reset_check();
        wr(4'd5, 32'hDEAD_BEEF, 4'hF);
        rd_check("R1 R8 locked after reset", 4'd5, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule